// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block picks the next instruction fetch address for a simple in-order 32-bit processor. The processor uses 16-bit instructions, so fetch normally advances by two bytes. The decode stage reports each branch to the block with a valid strobe, a branch kind, the condition sense and a resolved target address. The block also receives the current value of the status T flag and a pipeline stall.

Every unconditional jump is delayed. The instruction directly after it (the slot) always executes, and fetch continues at the target after that instruction. A conditional branch tests only the T flag against the sense bit it carries. It comes in two forms. The delayed form behaves like the jump when taken. The ordinary form redirects fetch without executing a slot, so a flush is raised for one cycle to discard the sequential instruction that was already fetched. A branch that appears in a slot is illegal. It is flagged, and it does not redirect fetch.

Top module: `delay_branch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` loads `RESET_VEC` (default 32'h0000_1000), and `flush` and the pending-slot state clear.
- R2: In a non-stalled cycle with no accepted branch, `fetch_pc` advances by 2 after the edge.
- R3: An accepted jump (`br_kind`=2'b00) loads `br_target` into `fetch_pc` at the next edge. The instruction fetched in the decode cycle is the slot, and it is kept.
- R4: A delayed branch (`br_kind` 2'b00 or 2'b01) never asserts `flush`.
- R5: A delayed conditional branch (`br_kind`=2'b01) is taken when `t_flag` equals `br_sense`, using the value `t_flag` has in the decode cycle. When taken, it redirects like R3.
- R6: A conditional branch of either form whose `t_flag` differs from `br_sense` advances `fetch_pc` by 2, with no flush.
- R7: A taken ordinary branch (`br_kind`=2'b10) loads `br_target` and raises `flush` for exactly one non-stalled cycle after the edge.
- R8: While `flush` is high, `br_valid` is ignored: fetch advances by 2 and no flush or slot follows. `br_kind`=2'b11 is never a branch.
- R9: A branch presented in the cycle after a delayed branch (its slot) drives `slot_illegal` high in that same cycle. Its redirect is suppressed, so `fetch_pc` advances by 2.
- R10: While `stall` is high, `fetch_pc`, `flush` and the pending-slot state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Pipeline stall; freezes all state |
| br_valid | input | 1 | Decode presents a branch this cycle |
| br_kind | input | 2 | 00 jump, 01 delayed conditional, 10 ordinary conditional, 11 none |
| br_sense | input | 1 | T value for which a conditional branch is taken |
| br_target | input | 32 | Resolved branch target address |
| t_flag | input | 1 | Current status T flag |
| fetch_pc | output | 32 | Address of the next instruction fetch |
| flush | output | 1 | Discard the instruction now in decode |
| slot_illegal | output | 1 | A branch was decoded inside a delay slot |

## Verification
The assertions check the following on every cycle: the address and flush freeze under stall, the single-cycle flush pulse, the absence of any flush after a delayed branch, the suppressed redirect of a branch found in a slot, and the reset values. The bench scenarios are the only place where the choice of target against PC+2 is shown to follow the T flag and sense for each branch kind. They also show that a branch arriving during a flush is ignored, and that a stalled ordinary branch keeps its flush pending.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        BK_JUMP = 2'b00,
        BK_CDLY = 2'b01,
        BK_CORD = 2'b10,
        BK_NONE = 2'b11
    } br_kind_e;

    typedef struct packed {
        logic redirect;
        logic opens_slot;
        logic kill_next;
        logic illegal;
    } br_decision_t;

    localparam br_decision_t DEC_IDLE = '{redirect: 1'b0, opens_slot: 1'b0,
                                          kill_next: 1'b0, illegal: 1'b0};

    function automatic logic cond_met(input logic sense, input logic t);
        return sense == t;
    endfunction

    function automatic logic is_delayed(input br_kind_e k);
        return (k == BK_JUMP) || (k == BK_CDLY);
    endfunction

endpackage

// File: rtl/branch_resolve.sv
module branch_resolve
    import pcseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         stall,
    input  logic         br_valid,
    input  br_kind_e     br_kind,
    input  logic         br_sense,
    input  logic         t_flag,
    input  logic         in_slot,
    input  logic         squash,
    output br_decision_t dec
);
    logic active;

    assign active = br_valid && !squash && (br_kind != BK_NONE);

    always_comb begin
        dec = DEC_IDLE;
        if (active) begin
            if (in_slot) begin
                dec.illegal = 1'b1;
            end else begin
                unique case (br_kind)
                    BK_JUMP: begin
                        dec.redirect   = 1'b1;
                        dec.opens_slot = 1'b1;
                    end
                    BK_CDLY: begin
                        dec.redirect   = cond_met(br_sense, t_flag);
                        dec.opens_slot = 1'b1;
                    end
                    BK_CORD: begin
                        dec.redirect   = cond_met(br_sense, t_flag);
                        dec.kill_next  = cond_met(br_sense, t_flag);
                    end
                    default: dec = DEC_IDLE;
                endcase
            end
        end
    end

    // R4
    dly_no_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && is_delayed(br_kind)) |-> !dec.kill_next);

    // R8
    squash_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (squash && !stall) |-> !(dec.redirect || dec.opens_slot || dec.kill_next));

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
    import pcseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         stall,
    input  br_decision_t dec,
    output logic         in_slot,
    output logic         flush
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_slot <= 1'b0;
            flush   <= 1'b0;
        end else if (!stall) begin
            in_slot <= dec.opens_slot;
            flush   <= dec.kill_next;
        end
    end

    // R7
    flush_single_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && !stall) |=> !flush);

    // R10
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(flush) && $stable(in_slot)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!flush && !in_slot));

endmodule

// File: rtl/pc_register.sv
module pc_register #(
    parameter int          AW        = 32,
    parameter int          STEP      = 2,
    parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_VEC;
        else if (!stall)
            pc <= redirect ? target : pc + INC;
    end

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc));

    // R1
    pc_reset_chk: assert property (@(posedge clk)
        rst |=> (pc == RESET_VEC));

endmodule

// File: rtl/delay_branch_seq.sv
module delay_branch_seq
    import pcseq_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic          br_valid,
    input  logic [1:0]    br_kind,
    input  logic          br_sense,
    input  logic [AW-1:0] br_target,
    input  logic          t_flag,
    output logic [AW-1:0] fetch_pc,
    output logic          flush,
    output logic          slot_illegal
);
    localparam int INSN_BYTES = 2;

    br_decision_t dec;
    logic         in_slot;

    branch_resolve u_resolve (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .br_valid (br_valid),
        .br_kind  (br_kind_e'(br_kind)),
        .br_sense (br_sense),
        .t_flag   (t_flag),
        .in_slot  (in_slot),
        .squash   (flush),
        .dec      (dec)
    );

    slot_tracker u_slot (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .dec     (dec),
        .in_slot (in_slot),
        .flush   (flush)
    );

    pc_register #(
        .AW        (AW),
        .STEP      (INSN_BYTES),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .redirect (dec.redirect),
        .target   (br_target),
        .pc       (fetch_pc)
    );

    assign slot_illegal = dec.illegal;

    // R9
    slot_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_illegal && !stall) |=> (fetch_pc == $past(fetch_pc) + AW'(INSN_BYTES)));

    // R4
    delayed_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !flush && !stall && br_kind[1] == 1'b0) |=> !flush);

endmodule

// File: tb/delay_branch_seq_test.sv
module delay_branch_seq_test;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_kind = 2'b11;
    logic        br_sense = 1'b0;
    logic [31:0] br_target = '0;
    logic        t_flag = 1'b0;
    logic [31:0] fetch_pc;
    logic        flush;
    logic        slot_illegal;

    int errors = 0;
    int checks = 0;
    logic [31:0] base;

    always #5 clk = ~clk;

    delay_branch_seq uut (
        .clk(clk), .rst(rst), .stall(stall), .br_valid(br_valid),
        .br_kind(br_kind), .br_sense(br_sense), .br_target(br_target),
        .t_flag(t_flag), .fetch_pc(fetch_pc), .flush(flush),
        .slot_illegal(slot_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic s,
                         input logic [31:0] tg, input logic t);
        br_valid = v; br_kind = k; br_sense = s; br_target = tg; t_flag = t;
    endtask

    task automatic idle();
        drive(1'b0, 2'b11, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        chk("R1 pc", fetch_pc, RV);
        chk("R1 flush", {31'b0, flush}, 32'd0);
        chk("R1 illegal", {31'b0, slot_illegal}, 32'd0);
    endtask

    task automatic t_sequential();
        idle(); base = fetch_pc; tick();
        chk("R2 pc+2", fetch_pc, base + 2);
        tick();
        chk("R2 pc+4", fetch_pc, base + 4);
    endtask

    task automatic t_jump();
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0200, 1'b0); tick();
        chk("R3 target", fetch_pc, 32'h0000_0200);
        chk("R4 no flush", {31'b0, flush}, 32'd0);
        idle(); tick();
        chk("R3 after slot", fetch_pc, 32'h0000_0202);
        chk("R4 no flush slot", {31'b0, flush}, 32'd0);
    endtask

    task automatic t_cond_delayed();
        drive(1'b1, 2'b01, 1'b1, 32'h0000_0300, 1'b1); tick();
        chk("R5 taken T=1", fetch_pc, 32'h0000_0300);
        chk("R4 cdly flush", {31'b0, flush}, 32'd0);
        idle(); tick();
        drive(1'b1, 2'b01, 1'b0, 32'h0000_0340, 1'b0); tick();
        chk("R5 taken T=0", fetch_pc, 32'h0000_0340);
        idle(); tick();
        base = fetch_pc;
        drive(1'b1, 2'b01, 1'b1, 32'h0000_0380, 1'b0); tick();
        chk("R6 cdly not taken", fetch_pc, base + 2);
        chk("R6 no flush", {31'b0, flush}, 32'd0);
        idle(); tick();
    endtask

    task automatic t_ordinary();
        drive(1'b1, 2'b10, 1'b1, 32'h0000_0400, 1'b1); tick();
        chk("R7 target", fetch_pc, 32'h0000_0400);
        chk("R7 flush high", {31'b0, flush}, 32'd1);
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0700, 1'b0); tick();
        chk("R7 flush one cycle", {31'b0, flush}, 32'd0);
        chk("R8 ignored in flush", fetch_pc, 32'h0000_0402);
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0500, 1'b0); #1;
        chk("R8 no slot after flush", {31'b0, slot_illegal}, 32'd0);
        tick();
        chk("R8 branch accepted", fetch_pc, 32'h0000_0500);
        idle(); tick();
        base = fetch_pc;
        drive(1'b1, 2'b10, 1'b0, 32'h0000_0600, 1'b1); tick();
        chk("R6 ord not taken", fetch_pc, base + 2);
        chk("R6 ord no flush", {31'b0, flush}, 32'd0);
        base = fetch_pc;
        drive(1'b1, 2'b11, 1'b1, 32'h0000_0680, 1'b1); tick();
        chk("R8 kind 11 none", fetch_pc, base + 2);
        idle();
    endtask

    task automatic t_illegal();
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0800, 1'b0); tick();
        drive(1'b1, 2'b10, 1'b1, 32'h0000_0900, 1'b1); #1;
        chk("R9 flag", {31'b0, slot_illegal}, 32'd1);
        tick();
        chk("R9 suppressed", fetch_pc, 32'h0000_0802);
        chk("R9 no flush", {31'b0, flush}, 32'd0);
        idle(); #1;
        chk("R9 flag clears", {31'b0, slot_illegal}, 32'd0);
    endtask

    task automatic t_stall();
        base = fetch_pc;
        stall = 1'b1;
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0A00, 1'b0); tick(); tick();
        chk("R10 pc held", fetch_pc, base);
        stall = 1'b0;
        drive(1'b1, 2'b10, 1'b1, 32'h0000_0B00, 1'b1); tick();
        chk("R7 target pre-stall", fetch_pc, 32'h0000_0B00);
        idle(); stall = 1'b1; tick(); tick();
        chk("R10 flush held", {31'b0, flush}, 32'd1);
        chk("R10 pc held 2", fetch_pc, 32'h0000_0B00);
        stall = 1'b0; tick();
        chk("R10 released", fetch_pc, 32'h0000_0B02);
        chk("R7 flush drops", {31'b0, flush}, 32'd0);
        stall = 1'b1;
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0C00, 1'b0);
        stall = 1'b0; tick(); idle();
        stall = 1'b1; tick();
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0D00, 1'b0); #1;
        chk("R10 slot held", {31'b0, slot_illegal}, 32'd1);
        stall = 1'b0; idle(); tick();
    endtask

    task automatic t_reset_mid();
        drive(1'b1, 2'b10, 1'b1, 32'h0000_0E00, 1'b1); tick();
        idle(); rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 mid pc", fetch_pc, RV);
        chk("R1 mid flush", {31'b0, flush}, 32'd0);
    endtask

    initial begin
        #1;
        t_reset();
        t_sequential();
        t_jump();
        t_cond_delayed();
        t_ordinary();
        t_illegal();
        t_stall();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule